// File: doc/BRIEF.md
# Receiver Frequency Range Monitor

This block watches one receive channel of a clock-recovery receiver. It takes single-cycle strobes from two sources, both already synchronised to one system clock. One strobe marks each period of the recovered byte clock. The other marks each period of a local training reference. A window closes after a fixed number of recovered ticks. At that point the block counts how many reference ticks fell inside the window and compares the count with the number the reference rate implies. A count outside a parts-per-million tolerance band means the recovered oscillator has wandered.

When that happens, the block asserts `force_track` for one whole window, so that the oscillator follows the reference. It then releases the oscillator and judges the next window. The link is reported good on `link_fault_n` (active low fault) only after a released window lands inside the band. If the recovered strobe stops altogether, a timeout counted in reference ticks closes the window as a failure. A channel enable holds the block in the faulted, forced state. When the enable returns, the block restarts from a clean count.

Top module: `freq_range_monitor`

## Requirements
- R1: A window closes on the 2^WIN_LOG2-th recovered tick, counted from the end of the previous window, from reset, or from the enable rising. The verdict acts on the outputs two clock edges after that tick. Before that tick the outputs do not change.
- R2: With `half_rate`=0 the expected reference count per window is 2^WIN_LOG2. With `half_rate`=1 it is 2^(WIN_LOG2-1). The value of `half_rate` at the window's close selects which one applies.
- R3: The tolerance is floor(expected × PPM / 1,000,000) ticks. A count equal to expected ± tolerance is in range, and one tick beyond that is out of range.
- R4: An out-of-range verdict while released (probing or locked) raises `force_track` for the whole of the next window.
- R5: The verdict of a forced window is ignored: `force_track` drops after that window in every case, and the next window is judged.
- R6: `link_fault_n` is 0 whenever `force_track` is 1. It becomes 1 only after an in-range verdict on a released window, and it stays 1 while later verdicts are in range.
- R7: While `chan_en`=0, `force_track`=1 and `link_fault_n`=0 whatever the ticks do, and both counters are cleared. After `chan_en` rises, the first window is a forced window that starts from a count of zero.
- R8: If 2^(WIN_LOG2+1) reference ticks arrive before a window closes, the window closes with an out-of-range verdict.
- R9: After reset, `force_track`=1 and `link_fault_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable, 1 = monitoring active |
| rec_tick | input | 1 | One-cycle strobe per recovered byte-clock period |
| ref_tick | input | 1 | One-cycle strobe per training reference period |
| half_rate | input | 1 | 1 = reference at half character rate, 0 = full rate |
| force_track | output | 1 | 1 = oscillator must follow the reference |
| link_fault_n | output | 1 | 0 = link fault, 1 = recovered clock judged in range |

## Verification
The bench builds the block with WIN_LOG2=6 and PPM=50000. That gives a 64-tick window with a tolerance of 3 ticks at full rate and 1 tick at half rate. With these values both edges of the band, the one-tick-outside cases and the 128-tick timeout can all be reached in a few thousand cycles. They also let the run walk the full force, release and lock loop many times, at both reference rates and across an enable drop in the middle of a window.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  typedef enum logic [1:0] {
    ST_FORCE = 2'd0,
    ST_TRY   = 2'd1,
    ST_LOCK  = 2'd2
  } rfm_state_e;

  // Reference ticks expected in one window of 2**win_log2 recovered ticks
  function automatic int unsigned ref_expected(int unsigned win_log2, bit half);
    return half ? (32'd1 << (win_log2 - 1)) : (32'd1 << win_log2);
  endfunction

  // Allowed deviation in whole ticks, rounded down
  function automatic int unsigned ref_tolerance(int unsigned expc, int unsigned ppm);
    longint unsigned prod;
    prod = longint'(expc) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/rfm_window_counter.sv
module rfm_window_counter #(
  parameter int unsigned WIN_LOG2 = 12,
  parameter int unsigned CW       = WIN_LOG2 + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rec_tick,
  input  logic          ref_tick,
  output logic          done,
  output logic [CW-1:0] count,
  output logic          timed_out
);
  localparam logic [WIN_LOG2-1:0] REC_LAST = {WIN_LOG2{1'b1}};
  localparam logic [CW-1:0]       TMO      = CW'(1) << (WIN_LOG2 + 1);

  logic [WIN_LOG2-1:0] rec_cnt;
  logic [CW-1:0]       ref_cnt;
  logic [CW-1:0]       ref_next;
  logic                rec_last;
  logic                tmo_hit;
  logic                win_end;

  assign ref_next = ref_cnt + CW'(ref_tick);
  assign rec_last = rec_tick && (rec_cnt == REC_LAST);
  assign tmo_hit  = !rec_last && (ref_next == TMO);
  assign win_end  = rec_last || tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rec_cnt   <= '0;
      ref_cnt   <= '0;
      done      <= 1'b0;
      count     <= '0;
      timed_out <= 1'b0;
    end else begin
      done <= win_end;
      if (win_end) begin
        count     <= ref_next;
        timed_out <= tmo_hit;
        rec_cnt   <= '0;
        ref_cnt   <= '0;
      end else begin
        rec_cnt <= rec_cnt + WIN_LOG2'(rec_tick);
        ref_cnt <= ref_next;
      end
    end
  end

  AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_tick && rec_cnt == REC_LAST && !clear) |=> done) else $error("window did not close"); // R1
  AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt < TMO) else $error("reference count passed timeout"); // R8
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rec_cnt == '0 && ref_cnt == '0 && !done)) else $error("counters not cleared"); // R7

endmodule

// File: rtl/rfm_range_judge.sv
module rfm_range_judge
  import rfm_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 12,
  parameter int unsigned PPM      = 1500,
  parameter int unsigned CW       = WIN_LOG2 + 2
) (
  input  logic [CW-1:0] count,
  input  logic          timed_out,
  input  logic          half_rate,
  output logic          in_range
);
  logic [CW-1:0] lo_lim;
  logic [CW-1:0] hi_lim;

  // One bound pair per reference rate, chosen by the select input
  for (genvar g = 0; g < 2; g++) begin : g_rate
    localparam int unsigned EXPC = ref_expected(WIN_LOG2, g == 1);
    localparam int unsigned TOL  = ref_tolerance(EXPC, PPM);
    localparam logic [CW-1:0] LO = CW'(EXPC - TOL);
    localparam logic [CW-1:0] HI = CW'(EXPC + TOL);
    logic [CW-1:0] lo_w;
    logic [CW-1:0] hi_w;
    assign lo_w = LO;
    assign hi_w = HI;
  end

  always_comb begin
    lo_lim = half_rate ? g_rate[1].lo_w : g_rate[0].lo_w;
    hi_lim = half_rate ? g_rate[1].hi_w : g_rate[0].hi_w;
    in_range = !timed_out && (count >= lo_lim) && (count <= hi_lim);
  end

endmodule

// File: rtl/rfm_relock_fsm.sv
module rfm_relock_fsm
  import rfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic verdict_valid,
  input  logic in_range,
  output logic force_track,
  output logic link_fault_n
);
  rfm_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_en) begin
      st <= ST_FORCE;
    end else if (verdict_valid) begin
      unique case (st)
        ST_FORCE: st <= ST_TRY;
        ST_TRY:   st <= in_range ? ST_LOCK : ST_FORCE;
        ST_LOCK:  st <= in_range ? ST_LOCK : ST_FORCE;
        default:  st <= ST_FORCE;
      endcase
    end
  end

  assign force_track  = (st == ST_FORCE);
  assign link_fault_n = (st == ST_LOCK) && chan_en;

  AST_FORCE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_track) |-> ($past(!chan_en) || $past(verdict_valid && !in_range))) else $error("force without cause"); // R4
  AST_FORCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_track && verdict_valid && chan_en) |=> !force_track) else $error("force not released"); // R5
  AST_GOOD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_fault_n) |-> $past(verdict_valid && in_range)) else $error("link good without in-range verdict"); // R6
  AST_DISABLED_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> force_track) else $error("not forced while disabled"); // R7

endmodule

// File: rtl/freq_range_monitor.sv
module freq_range_monitor
  import rfm_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 12,
  parameter int unsigned PPM      = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic rec_tick,
  input  logic ref_tick,
  input  logic half_rate,
  output logic force_track,
  output logic link_fault_n
);
  localparam int unsigned CW = WIN_LOG2 + 2;

  logic          win_done;
  logic [CW-1:0] win_count;
  logic          win_timeout;
  logic          win_in_range;

  rfm_window_counter #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!chan_en),
    .rec_tick  (rec_tick),
    .ref_tick  (ref_tick),
    .done      (win_done),
    .count     (win_count),
    .timed_out (win_timeout)
  );

  rfm_range_judge #(.WIN_LOG2(WIN_LOG2), .PPM(PPM), .CW(CW)) u_judge (
    .count     (win_count),
    .timed_out (win_timeout),
    .half_rate (half_rate),
    .in_range  (win_in_range)
  );

  rfm_relock_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_en       (chan_en),
    .verdict_valid (win_done),
    .in_range      (win_in_range),
    .force_track   (force_track),
    .link_fault_n  (link_fault_n)
  );

  AST_FAULT_WHEN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    force_track |-> !link_fault_n) else $error("good link while forced"); // R6
  AST_TIMEOUT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_timeout) |-> !win_in_range) else $error("timeout judged in range"); // R8

endmodule

// File: tb/freq_range_monitor_test.sv
module freq_range_monitor_test;
  localparam int unsigned WL  = 6;
  localparam int unsigned PPM = 50000;
  localparam int W = 1 << WL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0;
  logic rec_tick = 1'b0;
  logic ref_tick = 1'b0;
  logic half_rate = 1'b0;
  logic force_track;
  logic link_fault_n;

  always #5 clk = ~clk;

  freq_range_monitor #(.WIN_LOG2(WL), .PPM(PPM)) uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rec_tick(rec_tick),
    .ref_tick(ref_tick), .half_rate(half_rate),
    .force_track(force_track), .link_fault_n(link_fault_n)
  );

  typedef struct {
    bit    frc;
    bit    good;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  int mst    = 0; // 0 forced, 1 probing, 2 locked
  bit done_all = 1'b0;

  function automatic bit band_ok(int cnt, bit h);
    int e;
    int t;
    e = h ? W / 2 : W;
    t = int'((longint'(e) * longint'(PPM)) / 64'd1000000);
    return (cnt >= e - t) && (cnt <= e + t);
  endfunction

  task automatic push(string tag);
    exp_t it;
    it.frc  = (mst == 0);
    it.good = (mst == 2);
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic drive(int nrec, int nref);
    int n;
    n = (nrec > nref) ? nrec : nref;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rec_tick = (i >= n - nrec);
      ref_tick = (i >= n - nref);
    end
    @(negedge clk);
    rec_tick = 1'b0;
    ref_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic window(int nref, bit h, bit tmo, string tag);
    bit v;
    half_rate = h;
    drive(tmo ? 0 : W, nref);
    v = !tmo && band_ok(nref, h);
    if (mst == 0) mst = 1;
    else mst = v ? 2 : 0;
    push(tag);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      exp_t it;
      wait (sb.size() != 0);
      it = sb.pop_front();
      checks++;
      if (force_track !== it.frc || link_fault_n !== it.good) begin
        fails++;
        $display("FAIL %s: force_track=%b link_fault_n=%b expected %b %b",
                 it.tag, force_track, link_fault_n, it.frc, it.good);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chan_en = 1'b1;
    @(negedge clk);
    push("R9 reset state");

    window(W,     0, 0, "R5 forced window released");
    window(W + 3, 0, 0, "R3 upper limit in range, R6 good");
    window(W - 3, 0, 0, "R3 lower limit in range");
    window(W + 4, 0, 0, "R3 one past upper, R4 force");
    window(W + 4, 0, 0, "R5 release despite bad count");
    window(W - 4, 0, 0, "R4 one below lower forces");
    window(W,     0, 0, "R5 release");
    window(W,     0, 0, "R6 lock");
    window(W / 2, 1, 0, "R2 half rate nominal");
    window(W / 2 + 1, 1, 0, "R2 R3 half rate at limit");
    window(W / 2 + 2, 1, 0, "R2 R3 half rate past limit");
    window(W / 2, 1, 0, "R5 release at half rate");
    window(W / 2 - 1, 1, 0, "R3 half rate lower limit");
    window(W,     1, 0, "R2 full count at half rate is out");
    window(W / 2, 1, 0, "R5 release");
    window(W / 2, 1, 0, "R6 lock half rate");
    window(2 * W, 0, 1, "R8 timeout forces");

    // R1: window length
    window(W, 0, 0, "R5 release");
    half_rate = 1'b0;
    drive(W - 1, W - 1);
    push("R1 no verdict before last tick");
    drive(1, 1);
    mst = 2;
    push("R1 verdict on last tick");

    // R7: enable handling
    @(negedge clk);
    chan_en = 1'b0;
    mst = 0;
    repeat (2) @(negedge clk);
    push("R7 disable forces fault");
    drive(W, W);
    drive(W, W);
    push("R7 ticks ignored while disabled");
    chan_en = 1'b1;
    drive(W / 2, W / 2);
    push("R7 partial window no verdict");
    chan_en = 1'b0;
    repeat (2) @(negedge clk);
    chan_en = 1'b1;
    window(W, 0, 0, "R7 fresh forced window after enable");
    window(W, 0, 0, "R7 counters cleared, lock");

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    done_all = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule